// File: doc/BRIEF.md
# Pushbutton Master Volume Controller

This block sets the master volume of an audio codec from two active-low pushbuttons, with no software involved. One button makes the output louder and the other makes it quieter. The block synchronises and debounces each button. Every accepted press moves a saturating attenuation value by one step, where 0 is the loudest setting.

The attenuation register is the single value that the codec is driven from. The same register is also the host-readable shadow copy, so a change made with the buttons is always visible to the host. The host can load a new level through a one-cycle write strobe.

The two button pins also carry the clock and data of a serial configuration memory. While the memory-access input is high, activity on the pins is ignored.

Top module: `pbvol_top`

## Requirements
- R1: After synchronous reset, `atten` equals the parameter `RESET_LEVEL` (default 0), and both buttons are taken as released.
- R2: A press counts only after the synchronised pin has been low for `DB_CYCLES` consecutive clock cycles. A shorter low pulse causes no step, and a button held down steps only once until it has been released for `DB_CYCLES` cycles.
- R3: An accepted press of `btn_up_n` lowers `atten` by 1 (louder). An accepted press of `btn_dn_n` raises it by 1 (quieter). The level moves by at most one step per cycle.
- R4: `atten` saturates. An up press at 0 leaves it at 0, and a down press at 63 leaves it at 63. It never wraps.
- R5: While `mem_busy` is high, the debounce counters are held cleared and no press is produced, whatever the pins do.
- R6: When up and down presses are accepted in the same cycle, `atten` does not change.
- R7: When `host_wr` is high, `atten` takes `host_wdata` at the next clock edge. This takes priority over any press in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_up_n | input | 1 | Louder button, active low; shared with the memory serial clock |
| btn_dn_n | input | 1 | Quieter button, active low; shared with the memory serial data |
| mem_busy | input | 1 | High while the shared pins carry memory traffic |
| host_wr | input | 1 | Host write strobe for the level |
| host_wdata | input | 6 | Level written by the host |
| atten | output | 6 | Current attenuation: drives the codec and is the host shadow read value |

## Verification
The bench exercises several corner cases:
- **Glitch filtering:** low pulses two cycles shorter than the debounce window. A filter that is off by a few cycles would step on these.
- **Long holds:** presses held five windows long. A design that repeats the step while the button is held would step more than once.
- **Saturation:** presses beyond both ends of the range. A design that wraps would jump between 0 and 63.
- **Simultaneous presses:** both buttons pressed together. A design that gives one button priority would drift by one step.
- **Memory traffic:** pin activity while `mem_busy` is high. A design that samples during this traffic would step.
- **Host write against a press:** a host write placed in the exact cycle a press is accepted. A design in which the press wins would leave the value off by one step.

// File: rtl/pbvol_pkg.sv
package pbvol_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD  = 2'd0,
        STEP_LOUD  = 2'd1,
        STEP_QUIET = 2'd2,
        STEP_LOAD  = 2'd3
    } step_cmd_e;

    typedef struct packed {
        logic up;
        logic dn;
    } press_t;

    function automatic step_cmd_e decode_cmd(input logic wr, input press_t p);
        if (wr)
            return STEP_LOAD;
        else if (p.up && !p.dn)
            return STEP_LOUD;
        else if (p.dn && !p.up)
            return STEP_QUIET;
        else
            return STEP_HOLD;
    endfunction

endpackage

// File: rtl/pbvol_debounce.sv
module pbvol_debounce #(
    parameter int DB_W      = 16,
    parameter int DB_CYCLES = 40000
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    input  logic hold,
    output logic press
);
    localparam logic [DB_W-1:0] LIMIT = DB_W'(DB_CYCLES - 1);

    logic [1:0]      sync_q;
    logic            clean_q;
    logic [DB_W-1:0] cnt_q;
    logic            differs;
    logic            settle;

    assign differs = sync_q[1] != clean_q;
    assign settle  = differs && (cnt_q == LIMIT);
    assign press   = !hold && settle && !sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= 2'b11;
            clean_q <= 1'b1;
            cnt_q   <= '0;
        end else begin
            sync_q <= {sync_q[0], pin_n};
            if (hold || !differs) begin
                cnt_q <= '0;
            end else if (settle) begin
                clean_q <= sync_q[1];
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_BUSY_NO_PRESS: assert property (@(posedge clk) disable iff (rst)
        hold |-> !press);                                   // R5
    AST_PRESS_ONESHOT: assert property (@(posedge clk) disable iff (rst)
        press |=> !press);                                  // R2
    AST_HOLD_NO_SETTLE: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(clean_q));                         // R5

endmodule

// File: rtl/pbvol_level.sv
module pbvol_level
    import pbvol_pkg::*;
#(
    parameter int LVL_W       = 6,
    parameter int RESET_LEVEL = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  press_t           press,
    input  logic             wr,
    input  logic [LVL_W-1:0] wdata,
    output logic [LVL_W-1:0] level
);
    localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};
    localparam logic [LVL_W-1:0] LVL_MIN = '0;
    localparam logic [LVL_W-1:0] LVL_RST = LVL_W'(RESET_LEVEL);

    step_cmd_e        cmd;
    logic [LVL_W-1:0] level_q;
    logic [LVL_W-1:0] level_d;

    assign cmd = decode_cmd(wr, press);

    always_comb begin
        level_d = level_q;
        unique case (cmd)
            STEP_LOAD:  level_d = wdata;
            STEP_LOUD:  if (level_q != LVL_MIN) level_d = level_q - 1'b1;
            STEP_QUIET: if (level_q != LVL_MAX) level_d = level_q + 1'b1;
            default:    level_d = level_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) level_q <= LVL_RST;
        else     level_q <= level_d;
    end

    assign level = level_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (level_q == LVL_MAX && press.dn && !press.up && !wr) |=> level_q == LVL_MAX);   // R4
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (level_q == LVL_MIN && press.up && !press.dn && !wr) |=> level_q == LVL_MIN);   // R4
    AST_HOST_WINS: assert property (@(posedge clk) disable iff (rst)
        wr |=> level_q == $past(wdata));                                                // R7
    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (press.up && press.dn && !wr) |=> $stable(level_q));                            // R6
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        !wr |=> (level_q == $past(level_q) || level_q == $past(level_q) + 1'b1
                 || level_q == $past(level_q) - 1'b1));                                 // R3
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!wr && !press.up && !press.dn) |=> $stable(level_q));                          // R2

endmodule

// File: rtl/pbvol_top.sv
module pbvol_top
    import pbvol_pkg::*;
#(
    parameter int LVL_W       = 6,
    parameter int DB_W        = 16,
    parameter int DB_CYCLES   = 40000,
    parameter int RESET_LEVEL = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             btn_up_n,
    input  logic             btn_dn_n,
    input  logic             mem_busy,
    input  logic             host_wr,
    input  logic [LVL_W-1:0] host_wdata,
    output logic [LVL_W-1:0] atten
);
    localparam int NBTN = 2;

    logic [NBTN-1:0] pins_n;
    logic [NBTN-1:0] hits;
    press_t          press;

    assign pins_n = {btn_up_n, btn_dn_n};

    for (genvar g = 0; g < NBTN; g++) begin : g_btn
        pbvol_debounce #(
            .DB_W      (DB_W),
            .DB_CYCLES (DB_CYCLES)
        ) u_db (
            .clk   (clk),
            .rst   (rst),
            .pin_n (pins_n[g]),
            .hold  (mem_busy),
            .press (hits[g])
        );
    end

    assign press.up = hits[1];
    assign press.dn = hits[0];

    pbvol_level #(
        .LVL_W       (LVL_W),
        .RESET_LEVEL (RESET_LEVEL)
    ) u_level (
        .clk   (clk),
        .rst   (rst),
        .press (press),
        .wr    (host_wr),
        .wdata (host_wdata),
        .level (atten)
    );

endmodule

// File: tb/sim_pbvol_top.sv
`timescale 1ns/1ps
module sim_pbvol_top;
    localparam int DB = 8;
    localparam int W  = 6;

    logic         clk = 0;
    logic         rst = 1;
    logic         up_n = 1, dn_n = 1, busy = 0, wr = 0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] atten;
    int total = 0, bad = 0;
    int model = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pbvol_top #(.LVL_W(W), .DB_W(16), .DB_CYCLES(DB), .RESET_LEVEL(0)) u0 (
        .clk(clk), .rst(rst), .btn_up_n(up_n), .btn_dn_n(dn_n), .mem_busy(busy),
        .host_wr(wr), .host_wdata(wdata), .atten(atten));

    function automatic int apply(int lv, bit u, bit d);
        if (u && !d) return (lv == 0) ? 0 : lv - 1;
        if (d && !u) return (lv == 63) ? 63 : lv + 1;
        return lv;
    endfunction

    task automatic check(string req, int expv);
        total++;
        if (int'(atten) != expv) begin
            bad++;
            $display("FAIL %s: atten=%0d expected=%0d", req, atten, expv);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(bit u, bit d, int len);
        @(negedge clk);
        up_n = !u; dn_n = !d;
        idle(len);
        up_n = 1; dn_n = 1;
        idle(DB + 6);
    endtask

    task automatic host_load(int v);
        @(negedge clk);
        wr = 1; wdata = W'(v);
        @(negedge clk);
        wr = 0;
        model = v;
    endtask

    task automatic busy_traffic();
        @(negedge clk);
        busy = 1;
        idle(3);
        for (int i = 0; i < 4 * DB; i++) begin
            up_n = $urandom % 2;
            dn_n = (i % 3 == 0) ? 1'b0 : 1'b1;
            idle(i % 2 == 0 ? 2 * DB : 1);
        end
        up_n = 1; dn_n = 1;
        idle(4);
        busy = 0;
        idle(DB + 6);
    endtask

    initial begin
        void'($urandom(32'd2718));
        idle(4);
        rst = 0;
        idle(2);
        check("R1 reset level", 0);

        push(1, 0, DB + 6);
        check("R4 floor at 0", 0);

        push(0, 1, DB + 6); model = 1;
        check("R3 quieter step", model);

        push(0, 1, DB - 2);
        check("R2 short glitch ignored", model);

        push(0, 1, 5 * DB); model = 2;
        check("R2 long hold single step", model);

        push(1, 0, DB + 6); model = 1;
        check("R3 louder step", model);

        push(1, 1, DB + 6);
        check("R6 both pressed", model);

        busy_traffic();
        check("R5 memory traffic ignored", model);

        host_load(62);
        check("R7 host load", 62);
        push(0, 1, DB + 6); model = 63;
        check("R3 step to 63", model);
        push(0, 1, DB + 6);
        check("R4 ceiling at 63", 63);

        // Host write lands on the cycle the press is accepted
        @(negedge clk);
        dn_n = 0;
        repeat (DB + 1) @(posedge clk);
        @(negedge clk);
        wr = 1; wdata = 6'd20;
        @(negedge clk);
        wr = 0;
        check("R7 host write beats press", 20);
        dn_n = 1;
        idle(DB + 6);
        model = 20;
        check("R7 press not applied after write", 20);

        for (int k = 0; k < 80; k++) begin
            int op = $urandom % 6;
            case (op)
                0, 1: begin push(1, 0, DB + ($urandom % 10)); model = apply(model, 1, 0); end
                2, 3: begin push(0, 1, DB + ($urandom % 10)); model = apply(model, 0, 1); end
                4:    push($urandom % 2 == 1, 1'b1, 1 + ($urandom % (DB - 1)));
                default: host_load((k % 4 == 0) ? ((k % 8 == 0) ? 0 : 63) : int'($urandom % 64));
            endcase
            check("R3 random sequence", model);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5ns * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: atten=%0d expected=done", atten);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule